// File: doc/BRIEF.md
# Translation-Invalidate Request Checker

This block decides the result of a request to flush tagged address translations. Each request carries the processor mode bits, the current privilege level, a per-type capability mask, the requested flush type and a 128-bit descriptor. The checks run in a fixed priority order. The first check that applies sets the outcome: an undefined-opcode fault, an exit to the hypervisor, a general-protection fault, a failed operation, or success.

The fault checks depend only on the mode. The failure checks depend on the type. The descriptor has three fields: a 16-bit context tag in bits [15:0], a reserved field in bits [63:16] that must be zero, and a linear address in bits [127:64]. Whether the tag and the address are checked depends on the type. On success the block sends a one-cycle command to the invalidation engine. The command carries the type, the tag and the address. A failure or a success also updates two condition flags. The outcome is registered on every request pulse and holds until the next request.

Top module: `inval_req_checker`

## Requirements
- R1: After reset the outcome code is 0 (none), both flags are 0 and the command strobe is low.
- R2: An undefined-opcode fault (code 1) wins over every other result. It occurs when virtualization is off, when protection is disabled, when virtual-8086 mode is on, or when long mode is active with a 32-bit code segment.
- R3: If R2 does not apply and the core runs as a guest, the outcome is a hypervisor exit (code 2).
- R4: If R2 and R3 do not apply and the privilege level is not 0, the outcome is a general-protection fault (code 3).
- R5: A type value of 4 or more, or a type whose bit in the capability mask (bit n for type n) is clear, gives failure (code 4).
- R6: A descriptor with any of bits [63:16] set gives failure (code 4).
- R7: Types 0, 1 and 3 give failure when the tag in bits [15:0] is zero. Type 2 succeeds whatever the tag is.
- R8: Type 0 gives failure when the address in bits [127:64] is not canonical, meaning bits [63:47] of the address are not all equal. The other types accept any address.
- R9: A failure sets both flags to 1. A success clears both flags. Fault outcomes (codes 1 to 3) leave the flags unchanged.
- R10: A success gives outcome code 5. In the cycle after the request edge it raises the command strobe for exactly one cycle, with the type (2 bits), the tag and the address on the command outputs.
- R11: Without a request pulse, the outcome and the flags hold their values and the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse |
| virt_on | input | 1 | Virtualization operation active |
| prot_en | input | 1 | Protection enabled |
| v86_mode | input | 1 | Virtual-8086 mode |
| long_mode | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is 64-bit |
| guest_mode | input | 1 | Core runs as guest |
| cpl | input | 2 | Current privilege level |
| cap_mask | input | 4 | Supported types, bit n for type n |
| req_type | input | 64 | Requested flush type |
| desc | input | 128 | Descriptor: address, reserved field, tag |
| outcome | output | 3 | 0 none, 1 UD, 2 exit, 3 GP, 4 fail, 5 ok |
| cf | output | 1 | Carry-style failure flag |
| zf | output | 1 | Zero-style failure flag |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_kind | output | 2 | Type of the issued command |
| cmd_tag | output | 16 | Context tag of the command |
| cmd_addr | output | 64 | Linear address of the command |

## Verification
All results come out one cycle after the edge that samples req_valid. That edge loads the outcome, the flags and the command outputs. The strobe then falls at the following edge unless a new request succeeds. The bench drives inputs on falling edges and checks the results on the next falling edge, one register stage later. It checks again after an idle cycle to confirm that the result holds and the strobe has dropped.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int TAG_W   = 16;
    localparam int ADDR_W  = 64;
    localparam int RSVD_W  = 48;
    localparam int DESC_W  = ADDR_W + RSVD_W + TAG_W;

    typedef enum logic [2:0] {
        OC_NONE = 3'd0,
        OC_UD   = 3'd1,
        OC_EXIT = 3'd2,
        OC_GP   = 3'd3,
        OC_FAIL = 3'd4,
        OC_OK   = 3'd5
    } outcome_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [RSVD_W-1:0] rsvd;
        logic [TAG_W-1:0]  tag;
    } desc_t;

    // True when every address bit from va_bits-1 upward equals the sign bit.
    function automatic logic addr_canonical(logic [ADDR_W-1:0] a, int unsigned va_bits);
        logic same;
        same = 1'b1;
        for (int i = 0; i < ADDR_W - 1; i++) begin
            if (i >= int'(va_bits) - 1 && a[i] != a[ADDR_W-1])
                same = 1'b0;
        end
        return same;
    endfunction

endpackage

// File: rtl/ivc_mode_gate.sv
module ivc_mode_gate
    import ivc_pkg::*;
(
    input  logic       virt_on,
    input  logic       prot_en,
    input  logic       v86_mode,
    input  logic       long_mode,
    input  logic       cs_long,
    input  logic       guest_mode,
    input  logic [1:0] cpl,
    output outcome_e   fault,
    output logic       pass
);
    logic undef_op;

    assign undef_op = !virt_on || !prot_en || v86_mode || (long_mode && !cs_long);

    always_comb begin
        pass  = 1'b0;
        fault = OC_NONE;
        if (undef_op)
            fault = OC_UD;
        else if (guest_mode)
            fault = OC_EXIT;
        else if (cpl != 2'd0)
            fault = OC_GP;
        else
            pass = 1'b1;
    end

    always_comb begin
        if (pass) a_r2_gate_clear: assert (fault == OC_NONE && virt_on && prot_en);
    end
endmodule

// File: rtl/ivc_desc_check.sv
module ivc_desc_check
    import ivc_pkg::*;
#(
    parameter int NUM_TYPES    = 4,
    parameter int TYPE_W       = 64,
    parameter int VA_BITS      = 48,
    parameter int ADDR_TYPE    = 0,
    parameter int ALL_CTX_TYPE = 2,
    localparam int KIND_W      = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
)(
    input  logic [TYPE_W-1:0]    req_type,
    input  logic [NUM_TYPES-1:0] cap_mask,
    input  desc_t                desc,
    output logic                 ok,
    output logic [KIND_W-1:0]    kind
);
    logic                 rsvd_clear;
    logic                 tag_nz;
    logic                 canon;
    logic                 in_range;
    logic [NUM_TYPES-1:0] legal;

    assign rsvd_clear = (desc.rsvd == '0);
    assign tag_nz     = (desc.tag != '0);
    assign canon      = addr_canonical(desc.addr, VA_BITS);
    assign in_range   = (req_type < TYPE_W'(NUM_TYPES));
    assign kind       = req_type[KIND_W-1:0];

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
        if (t == ALL_CTX_TYPE) begin : g_all
            assign legal[t] = cap_mask[t] && rsvd_clear;
        end else if (t == ADDR_TYPE) begin : g_addr
            assign legal[t] = cap_mask[t] && rsvd_clear && tag_nz && canon;
        end else begin : g_ctx
            assign legal[t] = cap_mask[t] && rsvd_clear && tag_nz;
        end
    end

    assign ok = in_range && legal[kind];

    always_comb begin
        if (ok) a_r6_rsvd_zero_on_ok: assert (desc.rsvd == '0);
    end
endmodule

// File: rtl/ivc_result_reg.sv
module ivc_result_reg
    import ivc_pkg::*;
#(
    parameter int KIND_W = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  outcome_e          fault,
    input  logic              pass,
    input  logic              ok,
    input  logic [KIND_W-1:0] kind,
    input  desc_t             desc,
    output outcome_e          outcome,
    output logic              cf,
    output logic              zf,
    output logic              cmd_valid,
    output logic [KIND_W-1:0] cmd_kind,
    output logic [TAG_W-1:0]  cmd_tag,
    output logic [ADDR_W-1:0] cmd_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            outcome   <= OC_NONE;
            cf        <= 1'b0;
            zf        <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_kind  <= '0;
            cmd_tag   <= '0;
            cmd_addr  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (req_valid) begin
                if (!pass) begin
                    outcome <= fault;
                end else if (ok) begin
                    outcome   <= OC_OK;
                    cf        <= 1'b0;
                    zf        <= 1'b0;
                    cmd_valid <= 1'b1;
                    cmd_kind  <= kind;
                    cmd_tag   <= desc.tag;
                    cmd_addr  <= desc.addr;
                end else begin
                    outcome <= OC_FAIL;
                    cf      <= 1'b1;
                    zf      <= 1'b1;
                end
            end
        end
    end

    a_r10_strobe_on_ok: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (outcome == OC_OK && !cf && !zf));
    a_r9_flags_agree: assert property (@(posedge clk) disable iff (rst)
        cf == zf);
    a_r9_fail_sets: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pass && !ok) |=> (cf && outcome == OC_FAIL));
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(outcome) && $stable(cf) && !cmd_valid));
endmodule

// File: rtl/inval_req_checker.sv
module inval_req_checker
    import ivc_pkg::*;
#(
    parameter int NUM_TYPES = 4,
    parameter int TYPE_W    = 64,
    parameter int VA_BITS   = 48,
    localparam int KIND_W   = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 virt_on,
    input  logic                 prot_en,
    input  logic                 v86_mode,
    input  logic                 long_mode,
    input  logic                 cs_long,
    input  logic                 guest_mode,
    input  logic [1:0]           cpl,
    input  logic [NUM_TYPES-1:0] cap_mask,
    input  logic [TYPE_W-1:0]    req_type,
    input  logic [DESC_W-1:0]    desc,
    output logic [2:0]           outcome,
    output logic                 cf,
    output logic                 zf,
    output logic                 cmd_valid,
    output logic [KIND_W-1:0]    cmd_kind,
    output logic [TAG_W-1:0]     cmd_tag,
    output logic [ADDR_W-1:0]    cmd_addr
);
    outcome_e          fault;
    outcome_e          outcome_q;
    logic              pass;
    logic              ok;
    logic [KIND_W-1:0] kind;
    desc_t             dsc;

    assign dsc     = desc_t'(desc);
    assign outcome = outcome_q;

    ivc_mode_gate u_gate (
        .virt_on   (virt_on),
        .prot_en   (prot_en),
        .v86_mode  (v86_mode),
        .long_mode (long_mode),
        .cs_long   (cs_long),
        .guest_mode(guest_mode),
        .cpl       (cpl),
        .fault     (fault),
        .pass      (pass)
    );

    ivc_desc_check #(
        .NUM_TYPES(NUM_TYPES),
        .TYPE_W   (TYPE_W),
        .VA_BITS  (VA_BITS)
    ) u_desc (
        .req_type(req_type),
        .cap_mask(cap_mask),
        .desc    (dsc),
        .ok      (ok),
        .kind    (kind)
    );

    ivc_result_reg #(.KIND_W(KIND_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .fault    (fault),
        .pass     (pass),
        .ok       (ok),
        .kind     (kind),
        .desc     (dsc),
        .outcome  (outcome_q),
        .cf       (cf),
        .zf       (zf),
        .cmd_valid(cmd_valid),
        .cmd_kind (cmd_kind),
        .cmd_tag  (cmd_tag),
        .cmd_addr (cmd_addr)
    );

    a_r2_ud_first: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!virt_on || !prot_en)) |=> (outcome == 3'd1));
    a_r3_guest_exit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && virt_on && prot_en && !v86_mode && !(long_mode && !cs_long) && guest_mode)
        |=> (outcome == 3'd2));
    a_r4_cpl_gp: assert property (@(posedge clk) disable iff (rst)
        (req_valid && virt_on && prot_en && !v86_mode && !(long_mode && !cs_long)
         && !guest_mode && cpl != 2'd0) |=> (outcome == 3'd3 && $stable(cf)));
    a_r7_all_ctx_tag_free: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pass && req_type == TYPE_W'(2) && cap_mask[2] && dsc.rsvd == '0)
        |=> (cmd_valid && cmd_kind == KIND_W'(2)));
endmodule

// File: tb/test_inval_req_checker.sv
module test_inval_req_checker;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         virt_on = 1'b0, prot_en = 1'b0, v86_mode = 1'b0;
    logic         long_mode = 1'b0, cs_long = 1'b0, guest_mode = 1'b0;
    logic [1:0]   cpl = 2'd0;
    logic [3:0]   cap_mask = 4'd0;
    logic [63:0]  req_type = 64'd0;
    logic [127:0] desc = '0;
    logic [2:0]   outcome;
    logic         cf, zf, cmd_valid;
    logic [1:0]   cmd_kind;
    logic [15:0]  cmd_tag;
    logic [63:0]  cmd_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_flag = 1'b0;
    bit done = 0;

    inval_req_checker i_inval_req_checker (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .virt_on(virt_on), .prot_en(prot_en), .v86_mode(v86_mode),
        .long_mode(long_mode), .cs_long(cs_long), .guest_mode(guest_mode),
        .cpl(cpl), .cap_mask(cap_mask), .req_type(req_type), .desc(desc),
        .outcome(outcome), .cf(cf), .zf(zf), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_tag(cmd_tag), .cmd_addr(cmd_addr)
    );

    always #2 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic canon_ref(logic [63:0] a);
        return (a[63:47] == 17'h0) || (a[63:47] == 17'h1ffff);
    endfunction

    function automatic int ref_outcome();
        if (!virt_on || !prot_en || v86_mode || (long_mode && !cs_long)) return 1;
        if (guest_mode) return 2;
        if (cpl != 0) return 3;
        if (req_type > 64'd3) return 4;
        if (!cap_mask[req_type[1:0]]) return 4;
        if (desc[63:16] != 0) return 4;
        if (req_type != 2 && desc[15:0] == 0) return 4;
        if (req_type == 0 && !canon_ref(desc[127:64])) return 4;
        return 5;
    endfunction

    function automatic string tag_of(int e);
        case (e)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5/R6/R7/R8";
            default: return "R10";
        endcase
    endfunction

    task automatic set_mode(logic v, logic p, logic v86, logic lm, logic csl, logic g, logic [1:0] c);
        virt_on = v; prot_en = p; v86_mode = v86; long_mode = lm;
        cs_long = csl; guest_mode = g; cpl = c;
    endtask

    task automatic do_req(bit idle_after);
        int e;
        @(negedge clk);
        req_valid = 1'b1;
        e = ref_outcome();
        @(negedge clk);
        req_valid = 1'b0;
        check(tag_of(e), 64'(outcome), 64'(e));
        if (e == 4) exp_flag = 1'b1;
        if (e == 5) exp_flag = 1'b0;
        check("R9 cf", 64'(cf), 64'(exp_flag));
        check("R9 zf", 64'(zf), 64'(exp_flag));
        check("R10 strobe", 64'(cmd_valid), 64'(e == 5));
        if (e == 5) begin
            check("R10 kind", 64'(cmd_kind), req_type);
            check("R10 tag", 64'(cmd_tag), 64'(desc[15:0]));
            check("R10 addr", cmd_addr, desc[127:64]);
        end
        if (idle_after) begin
            @(negedge clk);
            check("R11 hold", 64'(outcome), 64'(e));
            check("R11 flags", 64'(cf), 64'(exp_flag));
            check("R10 one cycle", 64'(cmd_valid), 64'd0);
        end
    endtask

    function automatic logic [127:0] mk_desc(logic [63:0] a, logic [47:0] r, logic [15:0] t);
        return {a, r, t};
    endfunction

    initial begin
        #600000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outcome", 64'(outcome), 64'd0);
        check("R1 cf", 64'(cf), 64'd0);
        check("R1 zf", 64'(zf), 64'd0);
        check("R1 strobe", 64'(cmd_valid), 64'd0);

        // Directed corner cases
        cap_mask = 4'hf;
        req_type = 64'd1;
        desc = mk_desc(64'h1000, 48'h0, 16'h5);
        set_mode(0, 1, 0, 1, 1, 1, 2'd3); do_req(1);           // R2 beats guest/cpl
        set_mode(1, 1, 0, 1, 0, 0, 2'd0); do_req(1);           // R2 long mode 32-bit cs
        set_mode(1, 1, 1, 0, 0, 1, 2'd0); do_req(1);           // R2 virtual-8086
        set_mode(1, 1, 0, 1, 1, 1, 2'd3); do_req(1);           // R3 beats cpl
        set_mode(1, 1, 0, 1, 1, 0, 2'd1); do_req(1);           // R4
        set_mode(1, 1, 0, 1, 1, 0, 2'd0);
        req_type = 64'd4; do_req(1);                           // R5 out of range
        req_type = 64'h1_0000_0001; do_req(1);                 // R5 huge type
        req_type = 64'd3; cap_mask = 4'b0111; do_req(1);       // R5 capability clear
        cap_mask = 4'hf;
        req_type = 64'd2; desc = mk_desc(64'h1000, 48'h0, 16'h0); do_req(1);     // R7 type 2 tag 0 ok
        set_mode(1, 1, 0, 1, 1, 0, 2'd2); do_req(1);           // R4 flags unchanged R9
        set_mode(1, 1, 0, 1, 1, 0, 2'd0);
        req_type = 64'd3; do_req(1);                           // R7 tag 0
        req_type = 64'd2; desc = mk_desc(64'h1000, 48'h1, 16'h0); do_req(1);     // R6 bit 16
        req_type = 64'd1; desc = mk_desc(64'h1000, 48'h8000_0000_0000, 16'h9); do_req(1); // R6 bit 63
        req_type = 64'd0; desc = mk_desc(64'h0000_8000_0000_0000, 48'h0, 16'h9); do_req(1); // R8 noncanon
        req_type = 64'd1; do_req(1);                           // R8 ignored for type 1
        req_type = 64'd0; desc = mk_desc(64'hffff_8000_0000_0000, 48'h0, 16'hffff); do_req(1); // R8 high canon
        desc = mk_desc(64'h0000_7fff_ffff_f000, 48'h0, 16'h1); do_req(0);        // back-to-back R10
        req_type = 64'd3; do_req(1);

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            logic [47:0] r;
            logic [15:0] t;
            int sel;
            set_mode(($urandom % 10) != 0, ($urandom % 10) != 0, ($urandom % 10) == 0,
                     ($urandom % 2) == 1, ($urandom % 8) != 0, ($urandom % 6) == 0,
                     (($urandom % 5) == 0) ? 2'(1 + $urandom % 3) : 2'd0);
            cap_mask = (($urandom % 3) == 0) ? 4'($urandom) : 4'hf;
            req_type = (($urandom % 10) == 0) ? {32'($urandom), 32'($urandom)} : 64'($urandom % 5);
            sel = $urandom % 3;
            a = {32'($urandom), 32'($urandom)};
            if (sel == 0) a[63:47] = 17'h0;
            else if (sel == 1) a[63:47] = 17'h1ffff;
            r = (($urandom % 5) == 0) ? (48'h1 << ($urandom % 48)) : 48'h0;
            t = (($urandom % 4) == 0) ? 16'h0 : 16'($urandom);
            desc = mk_desc(a, r, t);
            do_req(($urandom % 2) == 1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule